// File: doc/BRIEF.md
# Fixed-Point Tile Matrix Product Engine

This block computes one square tile of a matrix product C = A × B in signed fixed-point arithmetic. It fetches operands from two external single-port read memories that hold A and B row-major, multiplies each pair at full precision and sums the products in a wide accumulator. Each result element is scaled to the output format only once, after its whole dot product has been summed. It is then written to an external result memory.

The tile edge (`DIM`, 64 by default, a power of two), the operand width and fraction bits, and the result width and fraction bits are all parameters. The input and output formats are set independently, so narrow operands such as 16-bit Q1.14 values can produce a much wider stored result, for example 48 bits. The block is used by pulsing `start` once per tile and waiting for `done`.

Top module: `fxp_tile_mm`

## Requirements
- R1: While `rst` is high and in the cycles after it until a start, `a_rd_en`, `b_rd_en`, `c_wr_en` and `done` are all low.
- R2: A one-cycle `start` while the sequencer is idle begins one tile; a `start` that arrives while reads of a tile are still being issued has no effect, so each tile gives exactly DIM×DIM writes and one `done`.
- R3: The block reads one A/B pair per cycle. The A address is {row, k} and the B address is {k, col}, each field log2(DIM) bits with the first field in the upper half. Result elements are produced in row-major order, and `c_addr` = {row, col} steps by one per write.
- R4: Every product keeps all 2·IN_W bits, and the running sum keeps 2·IN_W + log2(DIM) bits. No partial sum is rounded or clipped before the last of the DIM products has been added.
- R5: When 2·IN_FRAC exceeds OUT_FRAC, the sum is shifted right by the difference after adding half of one output LSB. Exact ties therefore round toward positive infinity.
- R6: When OUT_FRAC is greater than or equal to 2·IN_FRAC, the sum is shifted left by the difference, with no loss.
- R7: A scaled value above the largest value of OUT_W-bit two's complement is written as that largest value. A value below the most negative value is written as the most negative value.
- R8: OUT_W may be wider than IN_W, and the result is then written sign-extended at full value.
- R9: `done` is high for exactly one cycle, in the cycle right after the write of element (DIM-1, DIM-1).
- R10: Inside a tile, consecutive result writes are exactly DIM cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute a tile |
| a_rd_en | output | 1 | Read strobe for the A memory |
| a_addr | output | 2·log2(DIM) | A address {row, k} |
| a_data | input | IN_W | A element, valid one cycle after the strobe |
| b_rd_en | output | 1 | Read strobe for the B memory |
| b_addr | output | 2·log2(DIM) | B address {k, col} |
| b_data | input | IN_W | B element, valid one cycle after the strobe |
| c_wr_en | output | 1 | Result write strobe |
| c_addr | output | 2·log2(DIM) | Result address {row, col} |
| c_data | output | OUT_W | Rounded and saturated result element |
| done | output | 1 | One-cycle pulse after the last write of the tile |

## Verification
The bench runs two small instances side by side, one narrowing with right shift and one widening with left shift. It targets the exact tie of half an output LSB in both signs: a design that truncates or rounds ties away from zero returns a result one off. It drives sums far past the output range in both directions, where a design that wraps instead of clipping writes a value of the wrong sign. It uses an identity-like A to expose swapped address fields and off-by-one accumulator clears, and it pulses `start` in the middle of a tile. A design that restarts on that pulse gives extra writes or a second `done`.

// File: rtl/fxp_mm_pkg.sv
package fxp_mm_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Control flags travelling down the pipeline with each operand pair
    typedef struct packed {
        logic valid;     // an operand pair is in this stage
        logic first;     // first product of an output element
        logic last;      // last product of an output element
        logic tile_end;  // last product of the whole tile
    } mm_flags_t;

    localparam mm_flags_t FLAGS_IDLE = '{valid: 1'b0, first: 1'b0, last: 1'b0, tile_end: 1'b0};

    function automatic int sum_width(input int in_w, input int dim);
        return 2 * in_w + $clog2(dim);
    endfunction

endpackage

// File: rtl/fxp_mm_seq.sv
module fxp_mm_seq
    import fxp_mm_pkg::*;
#(
    parameter int DIM = 64,
    localparam int LG = $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [LG-1:0] row_o,
    output logic [LG-1:0] col_o,
    output logic [LG-1:0] k_o,
    output mm_flags_t     flags_o
);
    localparam logic [LG-1:0] TOP = LG'(DIM - 1);

    seq_state_e    state;
    logic [LG-1:0] row_q, col_q, k_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            row_q <= '0;
            col_q <= '0;
            k_q   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        row_q <= '0;
                        col_q <= '0;
                        k_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    k_q <= k_q + 1'b1;
                    if (k_q == TOP) begin
                        col_q <= col_q + 1'b1;
                        if (col_q == TOP) begin
                            row_q <= row_q + 1'b1;
                            if (row_q == TOP) begin
                                state <= SEQ_IDLE;
                            end
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        flags_o          = FLAGS_IDLE;
        flags_o.valid    = (state == SEQ_RUN);
        flags_o.first    = flags_o.valid && (k_q == '0);
        flags_o.last     = flags_o.valid && (k_q == TOP);
        flags_o.tile_end = flags_o.last && (col_q == TOP) && (row_q == TOP);
    end

    assign row_o = row_q;
    assign col_o = col_q;
    assign k_o   = k_q;

endmodule

// File: rtl/fxp_mm_mac.sv
module fxp_mm_mac
    import fxp_mm_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 38,
    parameter int IDX_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IN_W-1:0]         a_i,
    input  logic [IN_W-1:0]         b_i,
    input  mm_flags_t               flags_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic signed [ACC_W-1:0] acc_o,
    output mm_flags_t               flags_o,
    output logic [IDX_W-1:0]        idx_o
);
    localparam int PW = 2 * IN_W;

    logic signed [IN_W-1:0] a_s, b_s;
    logic signed [PW-1:0]   prod_q;
    mm_flags_t              prod_flags;
    logic [IDX_W-1:0]       prod_idx;

    assign a_s = $signed(a_i);
    assign b_s = $signed(b_i);

    // Stage 1: full-width product, nothing dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_flags <= FLAGS_IDLE;
            prod_q     <= '0;
            prod_idx   <= '0;
        end else begin
            prod_flags <= flags_i;
            prod_q     <= PW'(a_s) * PW'(b_s);
            prod_idx   <= idx_i;
        end
    end

    // Stage 2: wide running sum, restarted at the first product of an element
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o   <= '0;
            flags_o <= FLAGS_IDLE;
            idx_o   <= '0;
        end else begin
            flags_o <= prod_flags;
            idx_o   <= prod_idx;
            if (prod_flags.valid) begin
                if (prod_flags.first) begin
                    acc_o <= ACC_W'(prod_q);
                end else begin
                    acc_o <= acc_o + ACC_W'(prod_q);
                end
            end
        end
    end

endmodule

// File: rtl/fxp_mm_requant.sv
module fxp_mm_requant #(
    parameter int ACC_W = 38,
    parameter int SHIFT = 0,
    parameter int OUT_W = 48
) (
    input  logic signed [ACC_W-1:0] acc_i,
    output logic [OUT_W-1:0]        q_o
);
    localparam int SW = (SHIFT > 0) ? ACC_W + 1 : ACC_W - SHIFT;

    logic signed [SW-1:0] sh;

    generate
        if (SHIFT > 0) begin : g_narrow
            localparam logic [ACC_W:0] HALF = {{ACC_W{1'b0}}, 1'b1} << (SHIFT - 1);
            logic signed [ACC_W:0] biased;
            assign biased = $signed({acc_i[ACC_W-1], acc_i}) + $signed(HALF);
            assign sh     = biased >>> SHIFT;
        end else begin : g_widen
            localparam int LSH = -SHIFT;
            assign sh = SW'(acc_i) <<< LSH;
        end
    endgenerate

    generate
        if (OUT_W >= SW) begin : g_fit
            assign q_o = OUT_W'(sh);
        end else begin : g_clip
            localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W - 1){1'b1}}};
            localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W - 1){1'b0}}};
            logic in_range;
            assign in_range = (sh[SW-1:OUT_W-1] == {(SW - OUT_W + 1){sh[SW-1]}});
            assign q_o = in_range ? sh[OUT_W-1:0] : (sh[SW-1] ? NEG_MIN : POS_MAX);
        end
    endgenerate

endmodule

// File: rtl/fxp_tile_mm.sv
module fxp_tile_mm
    import fxp_mm_pkg::*;
#(
    parameter int DIM      = 64,
    parameter int IN_W     = 16,
    parameter int IN_FRAC  = 14,
    parameter int OUT_W    = 48,
    parameter int OUT_FRAC = 28,
    localparam int LG      = $clog2(DIM),
    localparam int AW      = 2 * LG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             a_rd_en,
    output logic [AW-1:0]    a_addr,
    input  logic [IN_W-1:0]  a_data,
    output logic             b_rd_en,
    output logic [AW-1:0]    b_addr,
    input  logic [IN_W-1:0]  b_data,
    output logic             c_wr_en,
    output logic [AW-1:0]    c_addr,
    output logic [OUT_W-1:0] c_data,
    output logic             done
);
    localparam int ACC_W = sum_width(IN_W, DIM);
    localparam int SHIFT = 2 * IN_FRAC - OUT_FRAC;

    logic [LG-1:0] row, col, k;
    mm_flags_t     seq_flags, mem_flags, acc_flags;
    logic [AW-1:0] mem_idx, acc_idx;
    logic signed [ACC_W-1:0] acc;
    logic [OUT_W-1:0]        q;
    logic                    wr_tile_end;

    fxp_mm_seq #(.DIM(DIM)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .row_o   (row),
        .col_o   (col),
        .k_o     (k),
        .flags_o (seq_flags)
    );

    assign a_rd_en = seq_flags.valid;
    assign b_rd_en = seq_flags.valid;
    assign a_addr  = {row, k};
    assign b_addr  = {k, col};

    // Aligns control with the one-cycle memory read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_flags <= FLAGS_IDLE;
            mem_idx   <= '0;
        end else begin
            mem_flags <= seq_flags;
            mem_idx   <= {row, col};
        end
    end

    fxp_mm_mac #(.IN_W(IN_W), .ACC_W(ACC_W), .IDX_W(AW)) mac_i (
        .clk     (clk),
        .rst     (rst),
        .a_i     (a_data),
        .b_i     (b_data),
        .flags_i (mem_flags),
        .idx_i   (mem_idx),
        .acc_o   (acc),
        .flags_o (acc_flags),
        .idx_o   (acc_idx)
    );

    fxp_mm_requant #(.ACC_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) rq_i (
        .acc_i (acc),
        .q_o   (q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            c_wr_en     <= 1'b0;
            c_addr      <= '0;
            c_data      <= '0;
            wr_tile_end <= 1'b0;
            done        <= 1'b0;
        end else begin
            c_wr_en     <= acc_flags.valid && acc_flags.last;
            c_addr      <= acc_idx;
            c_data      <= q;
            wr_tile_end <= acc_flags.valid && acc_flags.tile_end;
            done        <= c_wr_en && wr_tile_end;
        end
    end

endmodule

// File: rtl/fxp_mm_chk.sv
module fxp_mm_chk #(
    parameter int DIM = 64,
    parameter int LG  = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            a_rd_en,
    input logic            c_wr_en,
    input logic [2*LG-1:0] c_addr,
    input logic            done
);
    logic [2*LG-1:0] next_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_addr <= '0;
        end else if (c_wr_en) begin
            next_addr <= next_addr + 1'b1;
        end
    end

    AST_ROW_MAJOR_WRITES: assert property (@(posedge clk) disable iff (rst) c_wr_en |-> (c_addr == next_addr)); // R3
    AST_READ_NEEDS_START: assert property (@(posedge clk) disable iff (rst) $rose(a_rd_en) |-> $past(start)); // R2
    AST_DONE_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (rst) done |-> ($past(c_wr_en) && ($past(c_addr) == '1))); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_WRITES_SPACED: assert property (@(posedge clk) disable iff (rst) c_wr_en |=> !c_wr_en); // R10

endmodule

bind fxp_tile_mm fxp_mm_chk #(.DIM(DIM), .LG(LG)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .a_rd_en (a_rd_en),
    .c_wr_en (c_wr_en),
    .c_addr  (c_addr),
    .done    (done)
);

// File: tb/fxp_tile_mm_tb_top.sv
module fxp_tile_mm_tb_top;
    localparam int DIM = 4;
    localparam int NE  = DIM * DIM;
    localparam int IW  = 6;
    localparam int IF  = 4;
    localparam int OWA = 8;
    localparam int OFA = 4;   // narrowing: right shift by 4
    localparam int OWB = 20;
    localparam int OFB = 10;  // widening: left shift by 2
    localparam int AW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic clr = 1'b0;
    always #10 clk = ~clk;

    logic [IW-1:0] amem [NE];
    logic [IW-1:0] bmem [NE];

    logic a_en_a, b_en_a, wr_a, done_a;
    logic a_en_b, b_en_b, wr_b, done_b;
    logic [AW-1:0] aad_a, bad_a, cad_a, aad_b, bad_b, cad_b;
    logic [IW-1:0] aq_a, bq_a, aq_b, bq_b;
    logic [OWA-1:0] cd_a;
    logic [OWB-1:0] cd_b;

    fxp_tile_mm #(.DIM(DIM), .IN_W(IW), .IN_FRAC(IF), .OUT_W(OWA), .OUT_FRAC(OFA)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .a_rd_en(a_en_a), .a_addr(aad_a), .a_data(aq_a),
        .b_rd_en(b_en_a), .b_addr(bad_a), .b_data(bq_a),
        .c_wr_en(wr_a), .c_addr(cad_a), .c_data(cd_a), .done(done_a)
    );

    fxp_tile_mm #(.DIM(DIM), .IN_W(IW), .IN_FRAC(IF), .OUT_W(OWB), .OUT_FRAC(OFB)) dut_wide_i (
        .clk(clk), .rst(rst), .start(start),
        .a_rd_en(a_en_b), .a_addr(aad_b), .a_data(aq_b),
        .b_rd_en(b_en_b), .b_addr(bad_b), .b_data(bq_b),
        .c_wr_en(wr_b), .c_addr(cad_b), .c_data(cd_b), .done(done_b)
    );

    // Operand memories with one cycle of read latency
    always @(posedge clk) begin
        if (a_en_a) aq_a <= amem[aad_a];
        if (b_en_a) bq_a <= bmem[bad_a];
        if (a_en_b) aq_b <= amem[aad_b];
        if (b_en_b) bq_b <= bmem[bad_b];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    longint res_a [NE];
    longint res_b [NE];
    int wcnt_a, dcnt_a, ord_a, gap_a, lastw_a, dcyc_a;
    int wcnt_b, dcnt_b, ord_b, gap_b, lastw_b, dcyc_b;

    always @(posedge clk) begin
        if (clr) begin
            wcnt_a <= 0; dcnt_a <= 0; ord_a <= 0; gap_a <= 0; lastw_a <= 0; dcyc_a <= 0;
            wcnt_b <= 0; dcnt_b <= 0; ord_b <= 0; gap_b <= 0; lastw_b <= 0; dcyc_b <= 0;
        end else begin
            if (wr_a) begin
                res_a[cad_a] <= longint'($signed(cd_a));
                wcnt_a  <= wcnt_a + 1;
                lastw_a <= cyc;
                if (int'(cad_a) != wcnt_a % NE) ord_a <= ord_a + 1;
                if (wcnt_a > 0 && cyc - lastw_a != DIM) gap_a <= gap_a + 1;
            end
            if (done_a) begin dcnt_a <= dcnt_a + 1; dcyc_a <= cyc; end
            if (wr_b) begin
                res_b[cad_b] <= longint'($signed(cd_b));
                wcnt_b  <= wcnt_b + 1;
                lastw_b <= cyc;
                if (int'(cad_b) != wcnt_b % NE) ord_b <= ord_b + 1;
                if (wcnt_b > 0 && cyc - lastw_b != DIM) gap_b <= gap_b + 1;
            end
            if (done_b) begin dcnt_b <= dcnt_b + 1; dcyc_b <= cyc; end
        end
    end

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'd12345;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_elem(input int r, input int c, input int sh, input int ow);
        longint s = 0;
        longint hi = (longint'(1) <<< (ow - 1)) - 1;
        longint lo = -(longint'(1) <<< (ow - 1));
        for (int kk = 0; kk < DIM; kk++) begin
            s += longint'($signed(amem[r*DIM+kk])) * longint'($signed(bmem[kk*DIM+c]));
        end
        if (sh > 0) s = (s + (longint'(1) <<< (sh - 1))) >>> sh;
        else        s = s <<< (-sh);
        if (s > hi) s = hi;
        if (s < lo) s = lo;
        return s;
    endfunction

    task automatic fill(input int mode);
        for (int i = 0; i < NE; i++) begin
            int r = i / DIM;
            int c = i % DIM;
            case (mode)
                0: begin amem[i] = (r == c) ? IW'(16) : '0; bmem[i] = IW'(i - 8); end
                1: begin amem[i] = IW'(-32); bmem[i] = IW'(-32); end
                2: begin amem[i] = IW'(31); bmem[i] = IW'(-32); end
                3: begin
                    amem[i] = (c == 0) ? IW'(1) : '0;
                    case (c)
                        0: bmem[i] = (r == 0) ? IW'(8) : '0;
                        1: bmem[i] = (r == 0) ? IW'(-8) : '0;
                        2: bmem[i] = (r == 0) ? IW'(24) : '0;
                        default: bmem[i] = (r == 0) ? IW'(-24) : '0;
                    endcase
                end
                default: begin
                    seed = seed * 32'd1103515245 + 32'd12345;
                    amem[i] = IW'(seed >> 16);
                    seed = seed * 32'd1103515245 + 32'd12345;
                    bmem[i] = IW'(seed >> 16);
                end
            endcase
        end
    endtask

    task automatic run_tile(input int mode, input bit poke);
        int waited = 0;
        fill(mode);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while ((dcnt_a == 0 || dcnt_b == 0) && waited < 5000) begin
            @(negedge clk); waited++;
        end
        check(waited < 5000, "R2 tile completion", waited, 0);
        repeat (12) @(negedge clk);
        check(wcnt_a == NE, "R2 write count A", wcnt_a, NE);
        check(wcnt_b == NE, "R2 write count B", wcnt_b, NE);
        check(dcnt_a == 1, "R9 done count A", dcnt_a, 1);
        check(dcnt_b == 1, "R9 done count B", dcnt_b, 1);
        check(dcyc_a == lastw_a + 1, "R9 done timing A", dcyc_a, lastw_a + 1);
        check(dcyc_b == lastw_b + 1, "R9 done timing B", dcyc_b, lastw_b + 1);
        check(ord_a == 0 && ord_b == 0, "R3 row-major order", ord_a + ord_b, 0);
        check(gap_a == 0 && gap_b == 0, "R10 write spacing", gap_a + gap_b, 0);
        for (int i = 0; i < NE; i++) begin
            longint ea = ref_elem(i / DIM, i % DIM, 2*IF - OFA, OWA);
            longint eb = ref_elem(i / DIM, i % DIM, 2*IF - OFB, OWB);
            bool_check_a(res_a[i], ea);
            check(res_b[i] == eb, "R6 R8 widened element", res_b[i], eb);
        end
    endtask

    task automatic bool_check_a(input longint act, input longint exp);
        if (exp == 127 || exp == -128) check(act == exp, "R7 saturated element", act, exp);
        else                           check(act == exp, "R4 R5 rounded element", act, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs while reset is held
        check(!a_en_a && !b_en_a && !a_en_b && !b_en_b, "R1 reads in reset", a_en_a, 0);
        check(!wr_a && !wr_b, "R1 writes in reset", wr_a, 0);
        check(!done_a && !done_b, "R1 done in reset", done_a, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!a_en_a && !a_en_b, "R1 idle reads after reset", a_en_a, 0);
        check(!wr_a && !wr_b, "R1 idle writes after reset", wr_a, 0);
        check(!done_a && !done_b, "R1 idle done after reset", done_a, 0);
        run_tile(0, 1'b0);
        run_tile(1, 1'b0);
        run_tile(2, 1'b0);
        run_tile(3, 1'b0);
        run_tile(4, 1'b1);
        run_tile(4, 1'b0);
        run_tile(4, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule